// File: doc/BRIEF.md
# Framed Elastic Store

This block absorbs the small rate and phase differences between a line-side write clock and a system-side read clock for byte-wide framed data. Each write carries one byte and an optional start-of-frame strobe. The read side pulls one byte per read enable and gets a start-of-frame strobe on byte 0 of each frame. A frame is `FRAME_BYTES` long, and the storage ring holds two frames.

In normal mode the read pointer trails the write pointer by up to two frames. When the two pointers drift too close in either direction, the read side jumps a whole frame, so byte positions inside a frame never shift. A jump backwards repeats a frame. A jump forwards drops a frame. Each jump pulses `slip`, and `slip_drop` gives the direction.

A minimum-delay mode shrinks the working depth to `MIN_BYTES` for low latency. A bypass mode routes the write stream straight to the read outputs. In bypass the two clocks are expected to be the same clock. Two command inputs act on their rising edges only. The re-centre command sets the separation to one frame. The align command raises the separation to half a frame when it is smaller than that. The pointers cross between clock domains in Gray code through two-flop synchronizers.

Top module: `frame_elastic_buf`

## Requirements
- R1: With `es_enable` low, `rd_data`, `rd_sof` and `rd_vld` equal `wr_data`, `wr_sof` and `wr_en` as sampled at the previous `rclk` edge, and `slip` stays 0. After reset all outputs are 0.
- R2: With `es_enable` high, every `rd_en` yields `rd_vld` one `rclk` cycle later. Between slips and commands, bytes emerge in exactly the order they were written, with none missing or repeated.
- R3: In normal mode, `rd_sof` is high exactly on bytes that were written with `wr_sof` high. This holds across slips.
- R4: A 0-to-1 edge on `cmd_recentre` sets the read pointer one frame (32 bytes) behind the synchronized write pointer.
- R5: A 0-to-1 edge on `cmd_align` while the synchronized separation is below half a frame (16 bytes) sets the separation to exactly half a frame.
- R6: A 0-to-1 edge on `cmd_align` while the separation is half a frame or more leaves the read stream unchanged.
- R7: Holding `cmd_align` high causes no further alignment. The input must fall and rise again before the next one.
- R8: If a read finds a separation of 1 byte or less, the read pointer moves back one frame, repeating data. That byte is output with `slip`=1 and `slip_drop`=0.
- R9: If a read finds a separation of at least two frames minus `SLIP_GUARD` (58 bytes by default), the read pointer moves forward one frame, dropping data. That byte is output with `slip`=1 and `slip_drop`=1.
- R10: With `min_delay` high, `cmd_recentre` sets a 2-byte separation, the overflow limit becomes `MIN_BYTES` (4), and slips move the pointer by 2 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (line) clock |
| wrst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write one byte this cycle |
| wr_sof | input | 1 | Byte written this cycle is byte 0 of a frame |
| wr_data | input | DATA_W | Write byte |
| rclk | input | 1 | Read-side (system) clock |
| rrst | input | 1 | Synchronous active-high reset, read side |
| es_enable | input | 1 | 1 = use the store, 0 = bypass |
| min_delay | input | 1 | 1 = minimum-delay working depth |
| cmd_recentre | input | 1 | Rising edge re-centres the pointers one frame apart |
| cmd_align | input | 1 | Rising edge enforces half-frame minimum separation |
| rd_en | input | 1 | Read one byte this cycle |
| rd_vld | output | 1 | `rd_data` holds a byte |
| rd_sof | output | 1 | `rd_data` is byte 0 of a frame |
| rd_data | output | DATA_W | Read byte |
| slip | output | 1 | A frame slip took effect on this byte |
| slip_drop | output | 1 | 1 = frame dropped, 0 = frame repeated |

## Verification
The hardest cases to reach from the ports are the two threshold crossings and the align decision. All three depend on a pointer separation that is hidden and that reaches the read side only after synchronizer delay. The stimulus shapes that separation by controlling rates. Gaps inserted into the write stream drain the store toward underflow. Gaps in the read enables fill it toward overflow. A timed pause of the writer pulls the separation below half a frame just before align rises. The scoreboard indexes every written byte. It follows each backward or forward jump that `slip` reports and measures the delay of the read stream against the write count, which confirms each pointer move without looking inside the block.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_e;
endpackage

// File: rtl/fes_sync2.sv
module fes_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fes_ram.sv
module fes_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fes_wr_ctl.sv
module fes_wr_ctl #(
  parameter int PW    = 7,
  parameter int AW    = 6,
  parameter int OFS_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sof,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray
);
  logic [PW-1:0] wptr, cur, nxt;

  // A frame marker off a frame boundary snaps the pointer to the next frame.
  always_comb begin
    cur = wptr;
    if (wr_sof && (wptr[OFS_W-1:0] != '0))
      cur = {wptr[PW-1:OFS_W] + 1'b1, {OFS_W{1'b0}}};
    nxt = wr_en ? cur + 1'b1 : wptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= nxt;
      wgray <= nxt ^ (nxt >> 1);
    end
  end

  assign we    = wr_en;
  assign waddr = cur[AW-1:0];

  // R3: a byte written with a frame marker lands on offset 0 of a frame
  assert_sof_at_offset0_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sof) |=> (wptr[OFS_W-1:0] == OFS_W'(1)));
endmodule

// File: rtl/fes_rd_ctl.sv
module fes_rd_ctl
  import fes_pkg::*;
#(
  parameter int FRAME_BYTES = 32,
  parameter int MIN_BYTES   = 4,
  parameter int SLIP_GUARD  = 6,
  parameter int PW          = 7,
  parameter int AW          = 6,
  parameter int OFS_W       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          mdm,
  input  logic          cmd_rst,
  input  logic          cmd_aln,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          vld_q,
  output logic          sof_q,
  output logic          slip_q,
  output logic          drop_q
);
  localparam int DEPTH = 2 * FRAME_BYTES;
  localparam logic [PW-1:0] STEP_N = PW'(FRAME_BYTES);
  localparam logic [PW-1:0] STEP_M = PW'(MIN_BYTES / 2);
  localparam logic [PW-1:0] HI_N   = PW'(DEPTH - SLIP_GUARD);
  localparam logic [PW-1:0] HI_M   = PW'(MIN_BYTES);
  localparam logic [PW-1:0] ALN_N  = PW'(FRAME_BYTES / 2);
  localparam logic [PW-1:0] LO     = PW'(1);

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rptr, base, wbin, fill;
  logic [PW-1:0] step, hi, sep_ctr, sep_aln;
  logic          rst_q, aln_q, rst_rise, aln_rise;
  slip_e         kind;

  assign wbin     = gray2bin(wgray_s);
  assign fill     = wbin - rptr;
  assign rst_rise = cmd_rst & ~rst_q;
  assign aln_rise = cmd_aln & ~aln_q;
  assign step     = mdm ? STEP_M : STEP_N;
  assign hi       = mdm ? HI_M   : HI_N;
  assign sep_ctr  = mdm ? STEP_M : STEP_N;
  assign sep_aln  = mdm ? STEP_M : ALN_N;

  // Priority: re-centre, then align, then slips.
  always_comb begin
    base = rptr;
    kind = SLIP_NONE;
    if (en) begin
      if (rst_rise)
        base = wbin - sep_ctr;
      else if (aln_rise && (fill < sep_aln))
        base = wbin - sep_aln;
      else if (rd_en && (fill <= LO)) begin
        base = rptr - step;
        kind = SLIP_REPEAT;
      end else if (rd_en && (fill >= hi)) begin
        base = rptr + step;
        kind = SLIP_DROP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr   <= '0;
      rst_q  <= 1'b0;
      aln_q  <= 1'b0;
      vld_q  <= 1'b0;
      sof_q  <= 1'b0;
      slip_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      rst_q  <= cmd_rst;
      aln_q  <= cmd_aln;
      rptr   <= (en && rd_en) ? base + 1'b1 : base;
      vld_q  <= en && rd_en;
      sof_q  <= en && rd_en && (base[OFS_W-1:0] == '0);
      slip_q <= (kind != SLIP_NONE);
      drop_q <= (kind == SLIP_DROP);
    end
  end

  assign re    = en && rd_en;
  assign raddr = base[AW-1:0];

  // R1: bypass produces neither reads nor slips
  assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!slip_q && !vld_q));

  // R4: a re-centre edge wins over any slip decision
  assert_recentre_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (en && rst_rise) |=> !slip_q);

  // R7: without a read or a command edge the read pointer holds, even with align held high
  assert_held_align_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !rd_en && !rst_rise && !aln_rise) |=> (rptr == $past(rptr)));

  // R9: a drop indication always comes with a slip pulse
  assert_drop_is_slip_R9: assert property (@(posedge clk) disable iff (rst)
    drop_q |-> slip_q);
endmodule

// File: rtl/frame_elastic_buf.sv
module frame_elastic_buf #(
  parameter int DATA_W      = 8,
  parameter int FRAME_BYTES = 32,
  parameter int MIN_BYTES   = 4,
  parameter int SLIP_GUARD  = 6
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              es_enable,
  input  logic              min_delay,
  input  logic              cmd_recentre,
  input  logic              cmd_align,
  input  logic              rd_en,
  output logic              rd_vld,
  output logic              rd_sof,
  output logic [DATA_W-1:0] rd_data,
  output logic              slip,
  output logic              slip_drop
);
  localparam int DEPTH = 2 * FRAME_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int OFS_W = $clog2(FRAME_BYTES);

  logic              we, re;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, wgray_s;
  logic [DATA_W-1:0] ram_q;
  logic              st_vld, st_sof, st_slip, st_drop;
  logic              en_q, byp_vld, byp_sof;
  logic [DATA_W-1:0] byp_data;

  fes_wr_ctl #(.PW(PW), .AW(AW), .OFS_W(OFS_W)) u_wr (
    .clk(wclk), .rst(wrst), .wr_en(wr_en), .wr_sof(wr_sof),
    .we(we), .waddr(waddr), .wgray(wgray)
  );

  fes_sync2 #(.W(PW)) u_sync (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
  );

  fes_rd_ctl #(
    .FRAME_BYTES(FRAME_BYTES), .MIN_BYTES(MIN_BYTES), .SLIP_GUARD(SLIP_GUARD),
    .PW(PW), .AW(AW), .OFS_W(OFS_W)
  ) u_rd (
    .clk(rclk), .rst(rrst), .en(es_enable), .mdm(min_delay),
    .cmd_rst(cmd_recentre), .cmd_aln(cmd_align), .rd_en(rd_en),
    .wgray_s(wgray_s), .re(re), .raddr(raddr),
    .vld_q(st_vld), .sof_q(st_sof), .slip_q(st_slip), .drop_q(st_drop)
  );

  fes_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(re), .raddr(raddr), .rdata(ram_q)
  );

  // Bypass path: one register stage in the read domain.
  always_ff @(posedge rclk) begin
    if (rrst) begin
      en_q     <= 1'b0;
      byp_vld  <= 1'b0;
      byp_sof  <= 1'b0;
      byp_data <= '0;
    end else begin
      en_q     <= es_enable;
      byp_vld  <= wr_en;
      byp_sof  <= wr_sof;
      byp_data <= wr_data;
    end
  end

  assign rd_vld    = en_q ? st_vld : byp_vld;
  assign rd_sof    = en_q ? st_sof : byp_sof;
  assign rd_data   = en_q ? ram_q  : byp_data;
  assign slip      = st_slip;
  assign slip_drop = st_drop;
endmodule

// File: tb/frame_elastic_buf_tb_top.sv
module frame_elastic_buf_tb_top;
  logic       wclk = 0, rclk = 0, wrst = 1, rrst = 1;
  logic       wr_en = 0, wr_sof = 0;
  logic [7:0] wr_data = 0;
  logic       es_enable = 0, min_delay = 0, cmd_recentre = 0, cmd_align = 0, rd_en = 0;
  logic       rd_vld, rd_sof, slip, slip_drop;
  logic [7:0] rd_data;

  frame_elastic_buf dut_i (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_sof(wr_sof), .wr_data(wr_data),
    .rclk(rclk), .rrst(rrst), .es_enable(es_enable), .min_delay(min_delay),
    .cmd_recentre(cmd_recentre), .cmd_align(cmd_align), .rd_en(rd_en),
    .rd_vld(rd_vld), .rd_sof(rd_sof), .rd_data(rd_data),
    .slip(slip), .slip_drop(slip_drop)
  );

  always #5 rclk = ~rclk;
  initial begin #2; forever #5 wclk = ~wclk; end

  int n_chk = 0, n_bad = 0;
  bit wr_run = 0, rd_run = 0, mon_on = 0, locked = 0;
  int wr_gap = 0, rd_gap = 0, wcyc = 0, rcyc = 0, hold = 0;
  int wr_cnt = 0, idx = 0, cur_delay = 0, lock_delay = 0, n_unf = 0, n_ovf = 0;
  logic [7:0] sent_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_band(input string req, input string what, input int act, input int lo, input int hi);
    chk(act >= lo && act <= hi, req, $sformatf("%s in [%0d,%0d]", what, lo, hi), act, lo);
  endtask

  // Driver: one byte per write slot, each pushed into the scoreboard queue.
  task automatic drive_byte();
    wr_en   = 1;
    wr_data = wr_cnt[7:0];
    wr_sof  = (wr_cnt % 32 == 0);
    sent_q.push_back(wr_cnt[7:0]);
    wr_cnt++;
  endtask

  initial forever begin
    @(negedge wclk);
    if (wr_run && !(wr_gap != 0 && wcyc % wr_gap == 0)) drive_byte();
    else begin wr_en = 0; wr_sof = 0; end
    wcyc++;
  end

  initial forever begin
    @(negedge rclk);
    rd_en = rd_run && !(rd_gap != 0 && rcyc % rd_gap == 0);
    rcyc++;
  end

  // Monitor: follows the stream through the scoreboard queue.
  initial forever begin
    @(negedge rclk);
    if (hold > 0) hold--;
    else if (mon_on && rd_vld) begin
      if (!locked) begin
        int found;
        found = -1;
        for (int k = sent_q.size() - 1; k >= 0 && k >= sent_q.size() - 256; k--)
          if (sent_q[k] == rd_data) begin found = k; break; end
        chk(found >= 0, "R2", "locked byte was written", int'(rd_data), -1);
        if (found >= 0) begin
          idx = found; locked = 1; lock_delay = wr_cnt - idx;
        end
      end else begin
        if (slip) begin
          int jump;
          jump = min_delay ? 2 : 32;
          if (slip_drop) begin idx += jump; n_ovf++; end
          else begin idx -= jump; n_unf++; end
        end
        chk(rd_data == sent_q[idx], "R2", "stream order (slips R8/R9)", int'(rd_data), int'(sent_q[idx]));
      end
      if (locked) begin
        if (!min_delay)
          chk(rd_sof == (idx % 32 == 0), "R3", "frame start position", int'(rd_sof), int'(idx % 32 == 0));
        cur_delay = wr_cnt - idx;
        idx++;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge rclk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic waitr(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic unlock_edge(input bit is_align);
    @(negedge rclk);
    locked = 0; hold = 2;
    if (is_align) cmd_align = 1; else cmd_recentre = 1;
  endtask

  initial begin
    int u0, o0;
    waitr(5);
    @(negedge rclk); wrst = 0; rrst = 0;
    @(negedge rclk);
    chk(rd_vld == 0, "R1", "reset rd_vld", int'(rd_vld), 0);
    chk(slip == 0, "R1", "reset slip", int'(slip), 0);
    chk(rd_data == 0, "R1", "reset rd_data", int'(rd_data), 0);

    // Bypass, with a gapped write stream
    wr_run = 1; rd_run = 1; wr_gap = 3;
    waitr(10);
    for (int i = 0; i < 12; i++) begin
      @(negedge rclk);
      chk(rd_data == wr_data, "R1", "bypass data", int'(rd_data), int'(wr_data));
      chk(rd_vld == wr_en, "R1", "bypass valid", int'(rd_vld), int'(wr_en));
      chk(slip == 0, "R1", "bypass slip", int'(slip), 0);
    end
    wr_gap = 0;

    // Enable store and re-centre
    @(negedge rclk); es_enable = 1;
    waitr(100);
    mon_on = 1;
    unlock_edge(0);
    waitr(1); cmd_recentre = 0;
    waitr(60);
    chk_band("R4", "delay after re-centre", lock_delay, 31, 40);

    // Align with enough separation: no effect
    @(negedge rclk); cmd_align = 1;
    waitr(3); cmd_align = 0;
    waitr(40);
    chk_band("R6", "delay after idle align", cur_delay, 31, 40);
    chk(n_unf + n_ovf == 0, "R6", "no slip", n_unf + n_ovf, 0);

    // Pull separation below half a frame, then align
    wr_run = 0; waitr(26); wr_run = 1;
    waitr(20);
    chk_band("R5", "setup delay", cur_delay, 4, 14);
    unlock_edge(1);
    waitr(40);
    chk_band("R5", "delay after align", lock_delay, 17, 25);

    // Align held high: drain again, no realign allowed
    wr_run = 0; waitr(10); wr_run = 1;
    waitr(40);
    chk_band("R7", "delay with align held", cur_delay, 4, 15);
    @(negedge rclk); cmd_align = 0;
    waitr(3);
    unlock_edge(1);
    waitr(40);
    chk_band("R7", "delay after re-armed align", lock_delay, 17, 25);
    @(negedge rclk); cmd_align = 0;

    // Underflow: slow writer
    u0 = n_unf; o0 = n_ovf;
    wr_gap = 4; waitr(400); wr_gap = 0;
    chk(n_unf > u0, "R8", "repeat slips seen", n_unf - u0, 1);
    chk(n_ovf == o0, "R8", "no drop slips", n_ovf - o0, 0);
    waitr(20);

    // Overflow: slow reader
    u0 = n_unf; o0 = n_ovf;
    rd_gap = 4; waitr(600); rd_gap = 0;
    chk(n_ovf > o0, "R9", "drop slips seen", n_ovf - o0, 1);
    chk(n_unf == u0, "R9", "no repeat slips", n_unf - u0, 0);
    waitr(20);

    // Minimum-delay mode
    @(negedge rclk); min_delay = 1;
    unlock_edge(0);
    waitr(1); cmd_recentre = 0;
    waitr(40);
    chk_band("R10", "min-delay separation", lock_delay, 2, 9);
    o0 = n_ovf;
    rd_gap = 3; waitr(300); rd_gap = 0;
    chk(n_ovf > o0, "R10", "min-delay drop slips", n_ovf - o0, 1);
    waitr(20);

    finish_run();
  end
endmodule